// File: doc/BRIEF.md
# Indexed Configuration Register Window

This block is a two-location register window on a byte-wide I/O bus. Address offset 0 holds an index register. Offset 1 is a data port into a 256-entry array of configuration bytes, and it always acts on the entry the index points to. Software first writes the index, then reads or writes the selected entry through the data port. A separate enable input stands in for a bridge configuration bit. While it is low the window is unmapped: reads return all ones and writes do nothing.

A few entries come out of reset with fixed values. Two of them hold base addresses and are locked. Each one accepts only its own default value, and any other value written to it is silently dropped. The bus data input can be wider than a byte, but only its low eight bits are ever stored.

Reads are answered by a small response state machine with four states: `RSP_IDLE`, `RSP_DATA`, `RSP_INDEX` and `RSP_CLOSED`. A read strobe sampled on a clock edge moves it to one of the answering states:

- `RSP_IDLE`→`RSP_DATA` on a data-port read while enabled.
- `RSP_IDLE`→`RSP_INDEX` on an index-port read while enabled.
- `RSP_IDLE`→`RSP_CLOSED` on any read while disabled.

Any answering state goes back to `RSP_IDLE` when no read is sampled. It moves straight to another answering state when a further read is sampled. Each answering state drives `bus_rvalid` for one cycle, together with the captured byte (or 0xFF in `RSP_CLOSED`).

Top module: `cfgwin_top`

## Requirements
- R1: After reset the index is 0x00 and every entry reads 0x00, except these six: 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE and 0xE8=0xBE.
- R2: An enabled write to offset 0 (`bus_addr`=0) loads the low 8 bits of `bus_wdata` into the index on the sampling edge. An enabled read of offset 0 returns the index.
- R3: A read strobe sampled on edge N raises `bus_rvalid`, with `bus_rdata` valid, for the cycle after edge N. Without a sampled read, `bus_rvalid` is low. An enabled read of offset 1 returns the entry at the current index.
- R4: An enabled write to offset 1 stores the low 8 bits of `bus_wdata` into the entry at the current index on the sampling edge. This holds for every index except 0xE7 and 0xE8.
- R5: Entry 0xE7 accepts a data write only if the value is 0xFE. Any other value leaves the entry unchanged.
- R6: Entry 0xE8 accepts a data write only if the value is 0xBE. Any other value leaves the entry unchanged.
- R7: While `cfg_en` is low, reads of either offset return 0xFF, and writes to either offset change neither the index nor any entry.
- R8: The index keeps its value across any number of `cfg_en` toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Window enable; low unmaps both offsets |
| bus_addr | input | 1 | Port offset: 0 index, 1 data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | BUS_W | Write data; only bits 7:0 are used |
| bus_rdata | output | 8 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | High the cycle after a sampled read |

## Verification
A write takes effect on the edge that samples it, so a read strobe raised in the very next cycle must already see the new index or entry. Read data is due exactly one cycle after the edge that samples the read strobe. The bench drives one access per cycle from the falling edge and advances a behavioural model at the same moment. On the next falling edge it compares `bus_rvalid` and `bus_rdata` with the model's expectation, so every cycle is checked, idle cycles included. Writes that must be ignored (locked values, disabled window, upper data bits) are confirmed by reading the affected entry or index back afterwards.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    localparam int unsigned CW     = 8;
    localparam int unsigned IDX_W  = 8;
    localparam int unsigned DEPTH  = 1 << IDX_W;

    localparam logic [IDX_W-1:0] LOCK_A_IDX = 8'hE7;
    localparam logic [CW-1:0]    LOCK_A_VAL = 8'hFE;
    localparam logic [IDX_W-1:0] LOCK_B_IDX = 8'hE8;
    localparam logic [CW-1:0]    LOCK_B_VAL = 8'hBE;
    localparam logic [CW-1:0]    CLOSED_VAL = 8'hFF;

    typedef enum logic [1:0] {
        RSP_IDLE   = 2'd0,
        RSP_DATA   = 2'd1,
        RSP_INDEX  = 2'd2,
        RSP_CLOSED = 2'd3
    } rsp_state_e;

    function automatic logic [CW-1:0] reset_value(input logic [IDX_W-1:0] idx);
        logic [CW-1:0] v;
        case (idx)
            8'hE0:      v = 8'h3C;
            8'hE2:      v = 8'h03;
            8'hE3:      v = 8'hFC;
            8'hE6:      v = 8'hDE;
            LOCK_A_IDX: v = LOCK_A_VAL;
            LOCK_B_IDX: v = LOCK_B_VAL;
            default:    v = '0;
        endcase
        return v;
    endfunction

    function automatic logic write_allowed(input logic [IDX_W-1:0] idx,
                                           input logic [CW-1:0]    val);
        logic ok;
        if (idx == LOCK_A_IDX)      ok = (val == LOCK_A_VAL);
        else if (idx == LOCK_B_IDX) ok = (val == LOCK_B_VAL);
        else                        ok = 1'b1;
        return ok;
    endfunction

endpackage

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
    import cfgwin_pkg::*;
#(
    parameter int unsigned BUS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [IDX_W-1:0]  idx_q,
    output logic [CW-1:0]     wbyte,
    output logic              data_we,
    output logic              data_re,
    output logic              idx_re,
    output logic              miss_re
);

    logic idx_we;

    assign wbyte   = bus_wdata[CW-1:0];
    assign idx_we  = cfg_en & bus_wr & ~bus_addr;
    assign data_we = cfg_en & bus_wr &  bus_addr;
    assign data_re = cfg_en & bus_rd &  bus_addr;
    assign idx_re  = cfg_en & bus_rd & ~bus_addr;
    assign miss_re = ~cfg_en & bus_rd;

    generate
        if (BUS_W > CW) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^bus_wdata[BUS_W-1:CW];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_we) idx_q <= wbyte;
    end

    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && bus_wr && !bus_addr) |=> (idx_q == $past(bus_wdata[CW-1:0]))); // R2
    AST_IDX_KEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en) |=> $stable(idx_q)); // R8

endmodule

// File: rtl/cfgwin_store.sv
module cfgwin_store
    import cfgwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [CW-1:0]     wbyte,
    output logic [CW-1:0]     rbyte
);

    logic [CW-1:0] mem [DEPTH];
    logic          commit;

    assign commit = we & write_allowed(idx, wbyte);
    assign rbyte  = mem[idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= reset_value(IDX_W'(i));
        end else if (commit) begin
            mem[idx] <= wbyte;
        end
    end

    AST_LOCK_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == LOCK_A_IDX && wbyte != LOCK_A_VAL) |=> $stable(mem[LOCK_A_IDX])); // R5
    AST_LOCK_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == LOCK_B_IDX && wbyte != LOCK_B_VAL) |=> $stable(mem[LOCK_B_IDX])); // R6
    AST_OPEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx != LOCK_A_IDX && idx != LOCK_B_IDX) |=> (mem[$past(idx)] == $past(wbyte))); // R4

endmodule

// File: rtl/cfgwin_top.sv
module cfgwin_top
    import cfgwin_pkg::*;
#(
    parameter int unsigned BUS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [CW-1:0]     bus_rdata,
    output logic              bus_rvalid
);

    logic [IDX_W-1:0] idx_q;
    logic [CW-1:0]    wbyte;
    logic [CW-1:0]    rbyte;
    logic             data_we, data_re, idx_re, miss_re;
    logic [CW-1:0]    cap_q;
    rsp_state_e       state_q, state_d;

    cfgwin_decode #(.BUS_W(BUS_W)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_en),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .idx_q     (idx_q),
        .wbyte     (wbyte),
        .data_we   (data_we),
        .data_re   (data_re),
        .idx_re    (idx_re),
        .miss_re   (miss_re)
    );

    cfgwin_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (data_we),
        .idx   (idx_q),
        .wbyte (wbyte),
        .rbyte (rbyte)
    );

    // next response state: any sampled read selects its answering state
    always_comb begin
        if (data_re)      state_d = RSP_DATA;
        else if (idx_re)  state_d = RSP_INDEX;
        else if (miss_re) state_d = RSP_CLOSED;
        else              state_d = RSP_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            cap_q   <= '0;
        end else begin
            state_q <= state_d;
            if (data_re)     cap_q <= rbyte;
            else if (idx_re) cap_q <= idx_q;
        end
    end

    always_comb begin
        unique case (state_q)
            RSP_IDLE:   begin bus_rvalid = 1'b0; bus_rdata = '0;         end
            RSP_DATA:   begin bus_rvalid = 1'b1; bus_rdata = cap_q;      end
            RSP_INDEX:  begin bus_rvalid = 1'b1; bus_rdata = cap_q;      end
            RSP_CLOSED: begin bus_rvalid = 1'b1; bus_rdata = CLOSED_VAL; end
            default:    begin bus_rvalid = 1'b0; bus_rdata = '0;         end
        endcase
    end

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid); // R3
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid); // R3
    AST_CLOSED_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !cfg_en) |=> (bus_rdata == CLOSED_VAL)); // R7

endmodule

// File: tb/cfgwin_top_tb_top.sv
module cfgwin_top_tb_top;

    localparam int BUS_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_en = 1'b0;
    logic             bus_addr = 1'b0;
    logic             bus_wr = 1'b0;
    logic             bus_rd = 1'b0;
    logic [BUS_W-1:0] bus_wdata = '0;
    logic [7:0]       bus_rdata;
    logic             bus_rvalid;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;

    // behavioural reference
    logic [7:0] mdl [256];
    logic [7:0] mdl_idx;
    logic       exp_valid;
    logic [7:0] exp_data;
    string      prev_tag;
    bit         win;

    always #4 clk = ~clk;

    cfgwin_top #(.BUS_W(BUS_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_en     (cfg_en),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    task automatic check();
        n_tests++;
        if (bus_rvalid !== exp_valid || (exp_valid && bus_rdata !== exp_data)) begin
            n_fail++;
            $display("FAIL %s: rvalid=%0b rdata=%02h expected rvalid=%0b rdata=%02h",
                     prev_tag, bus_rvalid, bus_rdata, exp_valid, exp_data);
        end
    endtask

    task automatic step(input bit a, input bit wr, input bit rd,
                        input logic [BUS_W-1:0] d, input string tag);
        @(negedge clk);
        check();
        cfg_en    = win;
        bus_addr  = a;
        bus_wr    = wr;
        bus_rd    = rd;
        bus_wdata = d;
        exp_valid = rd;
        if (rd) exp_data = !win ? 8'hFF : (a ? mdl[mdl_idx] : mdl_idx);
        if (wr && win) begin
            if (!a) mdl_idx = d[7:0];
            else if (mdl_idx == 8'hE7) begin if (d[7:0] == 8'hFE) mdl[8'hE7] = d[7:0]; end
            else if (mdl_idx == 8'hE8) begin if (d[7:0] == 8'hBE) mdl[8'hE8] = d[7:0]; end
            else mdl[mdl_idx] = d[7:0];
        end
        prev_tag = tag;
    endtask

    task automatic set_idx(input logic [BUS_W-1:0] v, input string tag);
        step(1'b0, 1'b1, 1'b0, v, tag);
    endtask
    task automatic wr_data(input logic [BUS_W-1:0] v, input string tag);
        step(1'b1, 1'b1, 1'b0, v, tag);
    endtask
    task automatic rd_data(input string tag);
        step(1'b1, 1'b0, 1'b1, '0, tag);
    endtask
    task automatic rd_idx(input string tag);
        step(1'b0, 1'b0, 1'b1, '0, tag);
    endtask
    task automatic idle(input string tag);
        step(1'b0, 1'b0, 1'b0, '0, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
        mdl[8'hE0] = 8'h3C; mdl[8'hE2] = 8'h03; mdl[8'hE3] = 8'hFC;
        mdl[8'hE6] = 8'hDE; mdl[8'hE7] = 8'hFE; mdl[8'hE8] = 8'hBE;
        mdl_idx = 8'h00; exp_valid = 1'b0; exp_data = 8'h00;
        prev_tag = "R1 reset"; win = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset index and default contents
        rd_idx("R1 index after reset");
        rd_data("R1 entry 0x00 after reset");
        foreach (mdl[i]) begin
            if (i >= 8'hDF && i <= 8'hE9) begin
                set_idx(16'(i), "R2 index load");
                rd_data("R1 default entry");
            end
        end
        set_idx(16'h00FF, "R2 index load");
        rd_data("R1 last entry zero");

        // R2: index load uses low byte only, readback back-to-back
        set_idx(16'hA512, "R2 index low byte");
        rd_idx("R2 index readback");
        rd_idx("R3 back-to-back read");
        idle("R3 idle after read");

        // R4: open entries, low byte only, immediate visibility
        wr_data(16'hC35A, "R4 low byte stored");
        rd_data("R4 readback");
        set_idx(16'h0000, "R2 index load");
        wr_data(16'h0077, "R4 entry 0");
        rd_data("R4 entry 0 readback");
        set_idx(16'h00E0, "R2 index load");
        wr_data(16'h0011, "R4 reset-valued entry writable");
        rd_data("R4 entry E0 readback");
        set_idx(16'h00FF, "R2 index load");
        wr_data(16'h0099, "R4 top entry");
        rd_data("R4 top entry readback");
        set_idx(16'h0012, "R2 index load");
        rd_data("R4 earlier entry kept");

        // R5: locked entry 0xE7
        set_idx(16'h00E7, "R2 index load");
        wr_data(16'h0012, "R5 wrong value");
        rd_data("R5 unchanged");
        wr_data(16'h00FF, "R5 wrong value");
        wr_data(16'h01FE, "R5 permitted low byte");
        rd_data("R5 permitted value");
        wr_data(16'h00BE, "R5 other lock value");
        rd_data("R5 unchanged");

        // R6: locked entry 0xE8
        set_idx(16'h00E8, "R2 index load");
        wr_data(16'h0000, "R6 wrong value");
        rd_data("R6 unchanged");
        wr_data(16'h00FE, "R6 other lock value");
        rd_data("R6 unchanged");
        wr_data(16'h00BE, "R6 permitted value");
        rd_data("R6 permitted value");

        // R7/R8: disabled window
        set_idx(16'h0040, "R2 index load");
        wr_data(16'h0066, "R4 setup");
        win = 1'b0;
        rd_data("R7 data read closed");
        rd_idx("R7 index read closed");
        set_idx(16'h0041, "R7 index write ignored");
        wr_data(16'h0022, "R7 data write ignored");
        idle("R7 idle");
        win = 1'b1;
        rd_idx("R8 index kept across toggle");
        rd_data("R7 entry not written");
        for (int k = 0; k < 4; k++) begin
            win = k[0];
            idle("R8 toggling");
        end
        win = 1'b1;
        rd_idx("R8 index kept after toggles");
        rd_data("R8 entry still readable");
        set_idx(16'h0041, "R2 index load");
        rd_data("R7 neighbour untouched");
        idle("R3 final idle");
        idle("R3 final idle");

        @(negedge clk);
        check();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule